// File: doc/BRIEF.md
# Dual-Clock FIFO Fill-Level Flags

This block produces the threshold flags of a dual-clock FIFO. One side runs on the write clock and the other on the read clock. Each side keeps its own pointer and advances it on a one-cycle strobe. The write side strobe means a word was stored in memory. The read side strobe means a word left memory for the output register. A word held in the output register is no longer counted as being in memory.

Two flags are produced, both active low. The almost-empty flag lives in the read clock domain and falls when memory holds no more than the empty offset. The almost-full flag lives in the write clock domain and falls when memory is within the full offset of its depth. A third output, input-ready, also lives in the write domain and drops when memory is full. While input-ready is low, write strobes are refused.

A flag moves toward its cautious state on the very edge of a local event. It moves back only on the second edge of its own clock after the event in the other domain. Both offsets take preset values during reset. Software can replace them with a single parallel write on the write side.

Top module: `fifo_level_flags`

## Requirements
- R1: While reset is high, and right after it, `ae_n` is 0, `af_n` is 1 and `wr_ready` is 1, the fill level is zero, and the offsets hold their preset values (empty offset 3, full offset 4 by default).
- R2: Once settled, `ae_n` is 0 when memory holds at most X words and 1 when it holds X+1 or more, where X is the empty offset.
- R3: Once settled, `af_n` is 0 when memory holds at least DEPTH-Y words and 1 when it holds DEPTH-Y-1 or fewer, where Y is the full offset.
- R4: After a write raises memory to X+1 words, `ae_n` is still 0 after the first read-clock rising edge that follows the write. It becomes 1 on the second such edge.
- R5: After a read lowers memory to DEPTH-Y-1 words, `af_n` is still 0 after the first write-clock rising edge that follows the read. It becomes 1 on the second such edge.
- R6: A read that lowers memory to X words drives `ae_n` to 0 on the same read-clock edge that takes the read.
- R7: A write that raises memory to DEPTH-Y words drives `af_n` to 0 on the same write-clock edge that takes the write.
- R8: `wr_ready` is 0 while memory holds DEPTH words and 1 below that. A write strobe seen while `wr_ready` is 0 stores nothing and leaves the fill level unchanged.
- R9: With `cfg_we` high on a write-clock edge, X is loaded from `cfg_ae_off` and Y from `cfg_af_off`. Both flags then follow the new thresholds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst | input | 1 | Synchronous active-high reset, sampled by both clocks |
| wr_inc | input | 1 | One word stored in memory (write-clock strobe) |
| cfg_we | input | 1 | Parallel load of both offsets (write clock) |
| cfg_ae_off | input | $clog2(DEPTH) | New empty offset X |
| cfg_af_off | input | $clog2(DEPTH) | New full offset Y |
| rd_inc | input | 1 | One word moved from memory to the output register (read-clock strobe) |
| ae_n | output | 1 | Almost-empty, active low, read clock domain |
| af_n | output | 1 | Almost-full, active low, write clock domain |
| wr_ready | output | 1 | Input-ready: high while memory has room (write clock domain) |

## Verification
The properties assume three things about the inputs. Reset stays high until both clocks have seen it. The read strobe is never raised while memory, as seen from the read side, is empty. The offsets change only while no pointer movement is in flight. The stimulus honours all three. It issues reads only against a fill level it tracks itself. It changes offsets only after both domains have settled. It holds reset across several edges of each clock. The two clocks share a frequency but are offset in phase by a quarter period, so every cross-domain edge count in the latency checks is unambiguous.

// File: rtl/fifo_flags_pkg.sv
package fifo_flags_pkg;
  localparam int GW_MAX = 16;
  typedef logic [GW_MAX-1:0] gvec_t;

  function automatic gvec_t to_gray(gvec_t b);
    return b ^ (b >> 1);
  endfunction

  function automatic gvec_t from_gray(gvec_t g);
    gvec_t b;
    b[GW_MAX-1] = g[GW_MAX-1];
    for (int i = GW_MAX - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction
endpackage

// File: rtl/gray_ptr.sv
module gray_ptr #(
  parameter int PW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inc,
  output logic [PW-1:0] bin_q,
  output logic [PW-1:0] bin_nxt,
  output logic [PW-1:0] gray_q
);
  import fifo_flags_pkg::*;

  gvec_t ext_nxt;

  assign bin_nxt = bin_q + PW'(inc);
  assign ext_nxt = to_gray({{(GW_MAX-PW){1'b0}}, bin_nxt});

  always_ff @(posedge clk) begin
    if (rst) begin
      bin_q  <= '0;
      gray_q <= '0;
    end else begin
      bin_q  <= bin_nxt;
      gray_q <= ext_nxt[PW-1:0];
    end
  end
endmodule

// File: rtl/ptr_capture.sv
module ptr_capture #(
  parameter int PW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [PW-1:0] gray_in,
  output logic [PW-1:0] bin_out
);
  import fifo_flags_pkg::*;

  logic [PW-1:0] stage_q;
  gvec_t         dec;

  always_ff @(posedge clk) begin
    if (rst) stage_q <= '0;
    else     stage_q <= gray_in;
  end

  assign dec     = from_gray({{(GW_MAX-PW){1'b0}}, stage_q});
  assign bin_out = dec[PW-1:0];
endmodule

// File: rtl/fifo_level_flags.sv
module fifo_level_flags #(
  parameter int DEPTH     = 16,
  parameter int AE_PRESET = 3,
  parameter int AF_PRESET = 4
) (
  input  logic                     wclk,
  input  logic                     rclk,
  input  logic                     rst,
  input  logic                     wr_inc,
  input  logic                     cfg_we,
  input  logic [$clog2(DEPTH)-1:0] cfg_ae_off,
  input  logic [$clog2(DEPTH)-1:0] cfg_af_off,
  input  logic                     rd_inc,
  output logic                     ae_n,
  output logic                     af_n,
  output logic                     wr_ready
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

  logic [AW-1:0] x_off, y_off;
  logic [PW-1:0] wbin, wbin_nxt, wgray, rbin_w, wcnt_nxt;
  logic [PW-1:0] rbin, rbin_nxt, rgray, wbin_r, rcnt_nxt;
  logic          wr_acc;

  // ---------------- write clock domain ----------------
  assign wr_acc = wr_inc & wr_ready;

  always_ff @(posedge wclk) begin
    if (rst) begin
      x_off <= AW'(AE_PRESET);
      y_off <= AW'(AF_PRESET);
    end else if (cfg_we) begin
      x_off <= cfg_ae_off;
      y_off <= cfg_af_off;
    end
  end

  gray_ptr #(.PW(PW)) u_wptr (
    .clk(wclk), .rst(rst), .inc(wr_acc),
    .bin_q(wbin), .bin_nxt(wbin_nxt), .gray_q(wgray)
  );

  ptr_capture #(.PW(PW)) u_rsync (
    .clk(wclk), .rst(rst), .gray_in(rgray), .bin_out(rbin_w)
  );

  assign wcnt_nxt = wbin_nxt - rbin_w;

  always_ff @(posedge wclk) begin
    if (rst) begin
      af_n     <= 1'b1;
      wr_ready <= 1'b1;
    end else begin
      af_n     <= wcnt_nxt < (DEPTH_P - PW'(y_off));
      wr_ready <= wcnt_nxt < DEPTH_P;
    end
  end

  // ---------------- read clock domain ----------------
  gray_ptr #(.PW(PW)) u_rptr (
    .clk(rclk), .rst(rst), .inc(rd_inc),
    .bin_q(rbin), .bin_nxt(rbin_nxt), .gray_q(rgray)
  );

  ptr_capture #(.PW(PW)) u_wsync (
    .clk(rclk), .rst(rst), .gray_in(wgray), .bin_out(wbin_r)
  );

  assign rcnt_nxt = wbin_r - rbin_nxt;

  // x_off is quasi-static: only changed while no pointer moves
  always_ff @(posedge rclk) begin
    if (rst) ae_n <= 1'b0;
    else     ae_n <= rcnt_nxt > PW'(x_off);
  end
endmodule

// File: rtl/fifo_level_flags_chk.sv
module fifo_level_flags_chk #(
  parameter int PW = 5
) (
  input logic          wclk,
  input logic          rclk,
  input logic          rst,
  input logic          wr_inc,
  input logic          wr_ready,
  input logic          af_n,
  input logic [PW-1:0] wgray,
  input logic [PW-1:0] rgray,
  input logic [PW-1:0] wbin
);
  // R8: a full memory is always almost full
  p_full_implies_af_r8: assert property (@(posedge wclk) disable iff (rst)
    !wr_ready |-> !af_n);

  // R8: a refused write leaves the write pointer where it was
  p_no_write_when_full_r8: assert property (@(posedge wclk) disable iff (rst)
    (wr_inc && !wr_ready) |=> $stable(wbin));

  // R4: the write pointer crosses with at most one bit changing per edge
  p_wgray_step_r4: assert property (@(posedge wclk) disable iff (rst)
    $countones(wgray ^ $past(wgray)) <= 1);

  // R5: the read pointer crosses with at most one bit changing per edge
  p_rgray_step_r5: assert property (@(posedge rclk) disable iff (rst)
    $countones(rgray ^ $past(rgray)) <= 1);
endmodule

bind fifo_level_flags fifo_level_flags_chk #(.PW(PW)) u_chk (
  .wclk(wclk), .rclk(rclk), .rst(rst), .wr_inc(wr_inc),
  .wr_ready(wr_ready), .af_n(af_n), .wgray(wgray), .rgray(rgray), .wbin(wbin)
);

// File: tb/tb_fifo_level_flags.sv
`timescale 1ns/100ps
module tb_fifo_level_flags;
  localparam int DEPTH = 16;
  localparam int AW = $clog2(DEPTH);

  logic wclk, rclk, rst, wr_inc, cfg_we, rd_inc;
  logic [AW-1:0] cfg_ae_off, cfg_af_off;
  logic ae_n, af_n, wr_ready;
  int checks = 0, fails = 0;
  bit finished = 0;

  fifo_level_flags #(.DEPTH(DEPTH), .AE_PRESET(3), .AF_PRESET(4)) dut (
    .wclk(wclk), .rclk(rclk), .rst(rst), .wr_inc(wr_inc), .cfg_we(cfg_we),
    .cfg_ae_off(cfg_ae_off), .cfg_af_off(cfg_af_off), .rd_inc(rd_inc),
    .ae_n(ae_n), .af_n(af_n), .wr_ready(wr_ready)
  );

  // both 100 MHz; read clock lags by a quarter period
  initial begin wclk = 0; forever #5 wclk = ~wclk; end
  initial begin
    rclk = 0; #2.5;
    forever begin rclk = 1; #5; rclk = 0; #5; end
  end

  // {op(1=read), count[4:0], exp ae_n, exp af_n, exp wr_ready}; X=3, Y=4
  localparam logic [8:0] VEC [11] = '{
    {1'b0, 5'd3, 3'b011}, {1'b0, 5'd1, 3'b111}, {1'b0, 5'd7, 3'b111},
    {1'b0, 5'd1, 3'b101}, {1'b0, 5'd4, 3'b100}, {1'b0, 5'd2, 3'b100},
    {1'b1, 5'd1, 3'b101}, {1'b1, 5'd4, 3'b111}, {1'b1, 5'd7, 3'b111},
    {1'b1, 5'd1, 3'b011}, {1'b1, 5'd3, 3'b011}
  };

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
    end
  endtask

  task automatic write_n(int n);
    for (int i = 0; i < n; i++) begin @(negedge wclk); wr_inc = 1; end
    @(negedge wclk); wr_inc = 0;
  endtask

  task automatic read_n(int n);
    for (int i = 0; i < n; i++) begin @(negedge rclk); rd_inc = 1; end
    @(negedge rclk); rd_inc = 0;
  endtask

  task automatic load_cfg(int x, int y);
    @(negedge wclk); cfg_we = 1; cfg_ae_off = AW'(x); cfg_af_off = AW'(y);
    @(negedge wclk); cfg_we = 0;
  endtask

  task automatic settle();
    repeat (3) @(posedge wclk);
    repeat (3) @(posedge rclk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge wclk); rst = 1;
    repeat (4) @(posedge wclk);
    repeat (2) @(posedge rclk);
    #1;
    chk("R1 ae_n in reset", ae_n, 1'b0);
    chk("R1 af_n in reset", af_n, 1'b1);
    chk("R1 wr_ready in reset", wr_ready, 1'b1);
    @(negedge wclk); rst = 0;
    settle();
  endtask

  initial begin
    #200000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1; wr_inc = 0; rd_inc = 0; cfg_we = 0; cfg_ae_off = '0; cfg_af_off = '0;
    do_reset();

    // table walk: R2 / R3 / R8 thresholds, including the refused write at full
    for (int v = 0; v < 11; v++) begin
      if (VEC[v][8]) read_n(int'(VEC[v][7:3]));
      else           write_n(int'(VEC[v][7:3]));
      settle();
      chk("R2 ae_n level", ae_n, VEC[v][2]);
      chk("R3 af_n level", af_n, VEC[v][1]);
      chk("R8 wr_ready level", wr_ready, VEC[v][0]);
    end

    // R4: release latency of almost-empty (count 3 -> 4)
    write_n(3); settle();
    write_n(1);
    @(posedge rclk); #1; chk("R4 ae_n after first edge", ae_n, 1'b0);
    @(posedge rclk); #1; chk("R4 ae_n after second edge", ae_n, 1'b1);

    // R6: local read to X words asserts on the same edge
    read_n(1);
    chk("R6 ae_n on local read", ae_n, 1'b0);

    // R7: local write to DEPTH-Y words asserts on the same edge
    write_n(8); settle();
    chk("R3 af_n at 11 words", af_n, 1'b1);
    write_n(1);
    chk("R7 af_n on local write", af_n, 1'b0);

    // R5: release latency of almost-full (count 12 -> 11)
    read_n(1);
    chk("R5 af_n after first edge", af_n, 1'b0);
    @(posedge wclk); #1; chk("R5 af_n after second edge", af_n, 1'b1);

    // R9: offset load at 11 words
    load_cfg(11, 5); settle();
    chk("R9 ae_n with X=11", ae_n, 1'b0);
    chk("R9 af_n with Y=5", af_n, 1'b0);
    load_cfg(10, 6); settle();
    chk("R9 ae_n with X=10", ae_n, 1'b1);
    chk("R9 af_n with Y=6", af_n, 1'b0);

    // R1: reset from a non-empty state restores presets and zero fill
    do_reset();
    chk("R1 ae_n after reset", ae_n, 1'b0);
    write_n(4); settle();
    chk("R1 preset X restored", ae_n, 1'b1);
    write_n(7); settle();
    chk("R1 preset Y at 11 words", af_n, 1'b1);
    write_n(1); settle();
    chk("R1 preset Y at 12 words", af_n, 1'b0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule